// File: doc/BRIEF.md
# Serial Mouse Packet Encoder

This block turns one pointer event (signed X and Y motion plus three button states) into a fixed five-byte serial mouse packet. It places the packet bytes into an on-chip byte queue, and a host drains that queue one byte at a time. The first byte is a marker that carries the buttons as active-low bits. The next two bytes are the X motion and the inverted Y motion, each limited to a signed 8-bit range. Two zero bytes close the packet.

An event is offered with `ev_valid`, and the block takes it only while `ev_ready` is high. It then writes the five bytes into the queue, one per clock cycle, before it takes another event. The host pulses `rd_en` for one cycle. The byte (or zero when the queue is empty) appears on `rd_data` after the next rising edge. `rd_avail` reports that at least one byte is waiting.

Top module: `mouse_pkt_enc`

## Requirements
- R1: After a synchronous active-low reset, `rd_avail` is 0, `ev_ready` is 1 and `rd_data` is 0x00.
- R2: Packet byte 0 is 0x87 with bit 2 cleared when `ev_btn[2]` (left) is set, bit 1 cleared when `ev_btn[1]` (middle) is set, and bit 0 cleared when `ev_btn[0]` (right) is set.
- R3: Packet byte 1 is `ev_dx`, read as 16-bit two's complement and limited to −127..+127, sent as 8-bit two's complement. It is never 0x80.
- R4: Packet byte 2 is the negation of `ev_dy`, limited to −127..+127 and sent as 8-bit two's complement. A `ev_dy` of −32768 gives +127.
- R5: Packet bytes 3 and 4 are always 0x00.
- R6: Once an event is accepted, the five bytes enter the queue in order 0..4, one per clock. `ev_ready` is low for exactly five cycles after the accepting edge.
- R7: While `ev_ready` is low, `ev_valid` has no effect: no bytes are added and the packet in flight is unchanged.
- R8: The queue holds 256 bytes. A byte offered while the queue is full is dropped, and the bytes already stored are kept.
- R9: A read from an empty queue returns 0x00 on `rd_data`.
- R10: After a read, `rd_avail` stays high while bytes remain and falls once the last byte has been read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Encoder can take an event |
| ev_dx | input | 16 | Signed X motion |
| ev_dy | input | 16 | Signed Y motion |
| ev_btn | input | 3 | Buttons, bit 2 left, bit 1 middle, bit 0 right, 1 = pressed |
| rd_en | input | 1 | Read one byte from the queue |
| rd_data | output | 8 | Byte read, valid the cycle after `rd_en` |
| rd_avail | output | 1 | Queue holds at least one byte |

## Verification
The bench checks the saturation edges ±127, ±128 and ±32767/−32768 on both axes. Among these, −32768 on Y catches a negation done in 16 bits, which would wrap and send −127 instead of +127. Every button combination is checked against the inverted marker bits. A polarity slip would send 0x80-style markers with the wrong bits.

The bench overfills the queue to check that the first stored byte survives and that the 256th byte is the last one kept. A design with a full-flag off-by-one would lose or duplicate bytes at that boundary. The remaining cases cover a strobe held while busy, an empty read and the `rd_avail` transitions. These show a leaked extra packet, stale read data, or a flag that drops early.

// File: rtl/mouse_pkt_pkg.sv
// Package: shared sizes and the saturating byte helper for the mouse encoder.
// Assumes deltas no wider than 31 bits.
package mouse_pkt_pkg;
    localparam int PKT_LEN    = 5;
    localparam int BYTE_W     = 8;
    localparam logic [7:0] MARK_BASE = 8'h87;

    // Clamp a signed 32-bit value to -127..+127 and return it as a byte.
    function automatic logic [7:0] sat_byte(input logic signed [31:0] v);
        if (v > 32'sd127)       return 8'h7f;
        else if (v < -32'sd127) return 8'h81;
        else                    return v[7:0];
    endfunction
endpackage

// File: rtl/mouse_pkt_fmt.sv
// Module: builds the five packet bytes from one event, purely combinational.
// Assumes dx/dy are DW-bit two's complement; output byte k sits at bits [8k+7:8k].
module mouse_pkt_fmt
    import mouse_pkt_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [DW-1:0]             dx,
    input  logic [DW-1:0]             dy,
    input  logic [2:0]                btn,
    output logic [PKT_LEN*BYTE_W-1:0] pkt
);
    logic signed [31:0] dx_ext;
    logic signed [31:0] dy_neg;

    // Widen before negation so the most negative input cannot wrap.
    always_comb begin
        dx_ext = 32'(signed'(dx));
        dy_neg = -32'(signed'(dy));
        pkt    = '0;
        pkt[7:0]   = MARK_BASE ^ {5'b0, btn};
        pkt[15:8]  = sat_byte(dx_ext);
        pkt[23:16] = sat_byte(dy_neg);
    end
endmodule

// File: rtl/mouse_pkt_seq.sv
// Module: latches an accepted packet and pushes its bytes out one per clock.
// Assumes the downstream queue takes (or drops) a byte on every push.
module mouse_pkt_seq
    import mouse_pkt_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ev_valid,
    output logic                      ev_ready,
    input  logic [PKT_LEN*BYTE_W-1:0] pkt_in,
    output logic                      push,
    output logic [BYTE_W-1:0]         push_data
);
    localparam int IW = $clog2(PKT_LEN);

    logic                      busy;
    logic [IW-1:0]             idx;
    logic [PKT_LEN*BYTE_W-1:0] shreg;
    logic                      accept;

    assign ev_ready  = !busy;
    assign accept    = ev_valid && !busy;
    assign push      = busy;
    assign push_data = shreg[BYTE_W-1:0];

    // Load on accept, then shift one byte out per cycle until the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            idx   <= '0;
            shreg <= '0;
        end else if (accept) begin
            busy  <= 1'b1;
            idx   <= '0;
            shreg <= pkt_in;
        end else if (busy) begin
            shreg <= shreg >> BYTE_W;
            if (idx == IW'(PKT_LEN-1)) begin
                busy <= 1'b0;
                idx  <= '0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    a_r7_accept_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_ready) |=> !ev_ready);
    a_r6_first_push: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_ready) |=> push);
    a_r3_x_never_m128: assert property (@(posedge clk) disable iff (!rst_n)
        (push && idx == IW'(1)) |-> push_data != 8'h80);
    a_r4_y_never_m128: assert property (@(posedge clk) disable iff (!rst_n)
        (push && idx == IW'(2)) |-> push_data != 8'h80);
    a_r5_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (push && idx >= IW'(3)) |-> push_data == 8'h00);
endmodule

// File: rtl/mouse_byte_q.sv
// Module: circular byte queue with registered read data; full pushes are dropped.
// Assumes DEPTH is a power of two; an empty read returns zero.
module mouse_byte_q #(
    parameter int DEPTH = 256,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] pop_data,
    output logic         avail
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] count;
    logic          do_wr, do_rd;

    assign do_wr = push && (count < CW'(DEPTH));
    assign do_rd = pop && (count != '0);
    assign avail = (count != '0);

    // Storage write; no reset needed on the array.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wptr] <= push_data;
    end

    // Pointers, occupancy and registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr     <= '0;
            rptr     <= '0;
            count    <= '0;
            pop_data <= '0;
        end else begin
            if (do_wr) wptr <= wptr + 1'b1;
            if (do_rd) rptr <= rptr + 1'b1;
            count <= count + CW'(do_wr) - CW'(do_rd);
            if (pop) pop_data <= do_rd ? mem[rptr] : '0;
        end
    end

    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CW'(DEPTH) && push && !pop) |=> count == CW'(DEPTH));
    a_r9_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && count == '0) |=> pop_data == '0);
    a_r10_avail_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && count > CW'(1)) |=> avail);
endmodule

// File: rtl/mouse_pkt_enc.sv
// Module: top of the serial mouse packet encoder: formatter, byte sequencer, queue.
// Assumes a single clock domain and a synchronous active-low reset.
module mouse_pkt_enc
    import mouse_pkt_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_valid,
    output logic          ev_ready,
    input  logic [DW-1:0] ev_dx,
    input  logic [DW-1:0] ev_dy,
    input  logic [2:0]    ev_btn,
    input  logic          rd_en,
    output logic [7:0]    rd_data,
    output logic          rd_avail
);
    logic [PKT_LEN*BYTE_W-1:0] pkt;
    logic                      push;
    logic [BYTE_W-1:0]         push_data;

    mouse_pkt_fmt #(.DW(DW)) fmt_i (
        .dx(ev_dx), .dy(ev_dy), .btn(ev_btn), .pkt(pkt)
    );

    mouse_pkt_seq seq_i (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
        .pkt_in(pkt), .push(push), .push_data(push_data)
    );

    mouse_byte_q #(.DEPTH(DEPTH), .W(BYTE_W)) q_i (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
        .pop(rd_en), .pop_data(rd_data), .avail(rd_avail)
    );
endmodule

// File: tb/mouse_pkt_enc_tb.sv
module mouse_pkt_enc_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 9;
    // {dx[58:43], dy[42:27], btn[26:24], byte0[23:16], byte1[15:8], byte2[7:0]}
    localparam logic [58:0] VEC [NV] = '{
        {16'h0000, 16'h0000, 3'b000, 8'h87, 8'h00, 8'h00},
        {16'h0005, 16'h0003, 3'b100, 8'h83, 8'h05, 8'hFD},
        {16'hFFFB, 16'hFFFD, 3'b010, 8'h85, 8'hFB, 8'h03},
        {16'h007F, 16'hFF81, 3'b001, 8'h86, 8'h7F, 8'h7F},
        {16'h0080, 16'h0080, 3'b111, 8'h80, 8'h7F, 8'h81},
        {16'hFF80, 16'hFF80, 3'b000, 8'h87, 8'h81, 8'h7F},
        {16'h7FFF, 16'h8000, 3'b101, 8'h82, 8'h7F, 8'h7F},
        {16'h8000, 16'h7FFF, 3'b110, 8'h81, 8'h81, 8'h81},
        {16'hFF81, 16'h007F, 3'b011, 8'h84, 8'h81, 8'h81}
    };

    logic clk = 0, rst_n = 0, ev_valid = 0, rd_en = 0;
    logic [15:0] ev_dx = 0, ev_dy = 0;
    logic [2:0] ev_btn = 0;
    logic ev_ready, rd_avail;
    logic [7:0] rd_data;
    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mouse_pkt_enc dut_i (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
        .ev_dx(ev_dx), .ev_dy(ev_dy), .ev_btn(ev_btn),
        .rd_en(rd_en), .rd_data(rd_data), .rd_avail(rd_avail)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Offer one event and return the number of cycles ev_ready stayed low.
    task automatic send(input logic [15:0] dx, input logic [15:0] dy,
                        input logic [2:0] b, output int low_cycles);
        while (!ev_ready) @(negedge clk);
        ev_dx = dx; ev_dy = dy; ev_btn = b; ev_valid = 1;
        @(negedge clk);
        ev_valid = 0;
        low_cycles = 0;
        while (!ev_ready) begin low_cycles++; @(negedge clk); end
    endtask

    task automatic read_byte(output logic [7:0] d);
        rd_en = 1;
        @(negedge clk);
        rd_en = 0;
        d = rd_data;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int lc;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 avail", rd_avail, 0);
        check("R1 ready", ev_ready, 1);
        check("R1 data", rd_data, 0);

        // Table walk: R2 byte0, R3 byte1, R4 byte2, R5 tail, R6 timing
        for (int i = 0; i < NV; i++) begin
            send(VEC[i][58:43], VEC[i][42:27], VEC[i][26:24], lc);
            check("R6 busy cycles", lc, 5);
            read_byte(d); check("R2 byte0", d, VEC[i][23:16]);
            read_byte(d); check("R3 byte1", d, VEC[i][15:8]);
            read_byte(d); check("R4 byte2", d, VEC[i][7:0]);
            read_byte(d); check("R5 byte3", d, 0);
            check("R10 avail before last", rd_avail, 1);
            read_byte(d); check("R5 byte4", d, 0);
            check("R10 avail after last", rd_avail, 0);
        end

        // R9: empty read returns zero
        read_byte(d);
        check("R9 empty read", d, 0);

        // R7: strobe held while busy is ignored
        ev_dx = 16'h0011; ev_dy = 16'h0000; ev_btn = 3'b000; ev_valid = 1;
        @(negedge clk);
        ev_dx = 16'h0022; ev_btn = 3'b111;   // still valid, block busy
        repeat (2) @(negedge clk);
        ev_valid = 0;
        while (!ev_ready) @(negedge clk);
        read_byte(d); check("R7 byte0 kept", d, 8'h87);
        read_byte(d); check("R7 byte1 kept", d, 8'h11);
        repeat (3) read_byte(d);
        check("R7 no extra packet", rd_avail, 0);

        // R8: fill 255 bytes, then one more packet; only its first byte fits
        for (int p = 0; p < 51; p++) send(16'(p), 16'h0000, 3'b000, lc);
        send(16'h0001, 16'h0001, 3'b100, lc);
        read_byte(d); check("R8 first byte kept", d, 8'h87);
        read_byte(d); check("R8 second byte kept", d, 8'h00);
        for (int k = 2; k < 255; k++) read_byte(d);
        check("R10 avail one left", rd_avail, 1);
        read_byte(d); check("R8 last stored byte", d, 8'h83);
        check("R8 overflow dropped", rd_avail, 0);
        read_byte(d); check("R9 empty after drain", d, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule